// File: doc/BRIEF.md
# Protected Translation Cache

This block keeps recently used virtual-to-physical page mappings close to the pipeline. A requester presents a virtual page number, a page offset and a write flag. If a valid matching mapping is held, the block answers on the next cycle with the full physical address. If the access is a write and the page is marked read-only, it answers with an access fault instead.

When nothing matches, the block raises a refill request that carries the missing page number to an external table walker. It holds that lookup until the walker returns a physical page number and a read-only flag. The returned mapping is then installed and used to complete the held lookup.

Storage is set-associative. The low bits of the virtual page number select a set, and the remaining bits are kept as a tag in one of the ways. A flush input discards every mapping at once, for use when the address space changes. Apart from faults, software sees no effect from the block.

Top module: `xlat_cache`

## Requirements
- R1: During and right after a synchronous active-high reset, `resp_valid` and `miss_req` are low and `req_ready` is high; no mapping is held.
- R2: The set is chosen by the low log2(SETS) bits of the virtual page number (bits 3:0 by default), and the upper bits are the tag. A mapping installed in one set never answers a lookup aimed at another set, and it never answers a different tag in the same set.
- R3: A lookup accepted while a valid way of its set holds its tag gives, on the following cycle, `resp_valid`=1, `resp_hit`=1 and `resp_paddr` = {physical page number, offset}, with `miss_req` low.
- R4: A lookup that finds no valid matching way raises `miss_req` on the following cycle, with `miss_vpn` equal to its page number. `miss_req`, `miss_vpn` and a low `req_ready` stay unchanged until `fill_valid` arrives.
- R5: The cycle after `fill_valid` is taken, the held lookup completes with the returned page number and its own offset, `miss_req` drops, and later lookups of that page hit.
- R6: A write that hits, or completes through a refill of, a page whose read-only flag is 1 gives `resp_fault`=1, `resp_hit`=0 and `resp_paddr`=0. A read of the same page hits normally.
- R7: A refill goes into the lowest-numbered invalid way of the set. If every way is valid, it goes into the way named by the set's round-robin pointer, which starts at 0 and advances by one (wrapping) after each such replacement.
- R8: A one-cycle `flush` pulse invalidates every mapping, so every later lookup misses until it is refilled.
- R9: A lookup accepted in the same cycle as `flush` is treated as a miss.
- R10: When `flush` and `fill_valid` fall in the same cycle, the held lookup still completes with the returned mapping, but the mapping is not installed.
- R11: A response is never both a hit and a fault; with `resp_valid` high exactly one of `resp_hit` and `resp_fault` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup (no miss outstanding) |
| req_vpn | input | VPN_W | Virtual page number of the lookup |
| req_off | input | OFF_W | Page offset of the lookup |
| req_write | input | 1 | Lookup is a write access |
| resp_valid | output | 1 | Lookup response present this cycle |
| resp_hit | output | 1 | Response carries a valid translation |
| resp_fault | output | 1 | Response is an access fault (write to a read-only page) |
| resp_paddr | output | PPN_W+OFF_W | Translated physical address, zero on a fault |
| miss_req | output | 1 | Refill request to the table walker |
| miss_vpn | output | VPN_W | Page number whose mapping is requested |
| fill_valid | input | 1 | Walker returns a mapping |
| fill_ppn | input | PPN_W | Returned physical page number |
| fill_ro | input | 1 | Returned read-only flag |
| flush | input | 1 | Invalidate every mapping |

## Verification
Flush can fall in the same cycle as two other actions: a refill being installed and a new lookup being accepted. The bench times `flush` to land on the very edge that takes `fill_valid`. It checks that the held lookup still returns the correct address, and that a repeat lookup of that page then misses. It also presents a lookup together with a flush pulse and expects a refill request instead of a hit on a page that was resident just before. Replacement order is judged by filling every way of one set and then tracking which pages miss afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Controller state: accepting lookups, or holding one for a refill
  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xlat_state_e;

  // Width helper that never returns zero
  function automatic int unsigned safe_clog2(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 22,
  localparam int IDX_W = safe_clog2(SETS),
  localparam int WAY_W = safe_clog2(WAYS),
  localparam int ENT_W = TAG_W + PPN_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][PPN_W-1:0]  rd_ppn,
  output logic [WAYS-1:0]             rd_ro,
  output logic [WAYS-1:0]             rd_vld,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAYS-1:0]             wr_way,
  input  logic                        wr_rr_adv,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  logic                        wr_ro,
  output logic [WAYS-1:0]             wr_vld,
  output logic [WAY_W-1:0]            wr_rr
);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  // One RAM per way; no reset so it maps to memory primitives
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] mem [SETS];
    logic [ENT_W-1:0] rd_word;

    always_ff @(posedge clk) begin
      if (wr_en && wr_way[w]) begin
        mem[wr_idx] <= {wr_ro, wr_tag, wr_ppn};
      end
    end

    assign rd_word   = mem[rd_idx];
    assign rd_ro[w]  = rd_word[ENT_W-1];
    assign rd_tag[w] = rd_word[ENT_W-2 -: TAG_W];
    assign rd_ppn[w] = rd_word[PPN_W-1:0];
  end

  // Valid bits live in flops so a flush clears them all at once
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx] <= vld_q[wr_idx] | wr_way;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
      end
    end else if (wr_en && wr_rr_adv) begin
      if (rr_q[wr_idx] == WAY_W'(WAYS - 1)) begin
        rr_q[wr_idx] <= '0;
      end else begin
        rr_q[wr_idx] <= rr_q[wr_idx] + 1'b1;
      end
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign wr_vld = vld_q[wr_idx];
  assign wr_rr  = rr_q[wr_idx];

  logic any_vld;
  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      any_vld = any_vld | (|vld_q[s]);
    end
  end

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_vld);

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 22
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TAG_W-1:0]            tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]  rd_ppn,
  input  logic [WAYS-1:0]             rd_ro,
  input  logic [WAYS-1:0]             rd_vld,
  output logic                        hit,
  output logic [PPN_W-1:0]            hit_ppn,
  output logic                        hit_ro
);

  logic [WAYS-1:0] way_hit;

  always_comb begin
    hit_ppn = '0;
    hit_ro  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = rd_vld[w] && (rd_tag[w] == tag);
      if (way_hit[w]) begin
        hit_ppn = hit_ppn | rd_ppn[w];
        hit_ro  = hit_ro | rd_ro[w];
      end
    end
    hit = |way_hit;
  end

  // R5: refills happen only on misses, so a tag never sits in two ways
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int WAYS  = 4,
  localparam int WAY_W = safe_clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WAYS-1:0]  set_vld,
  input  logic [WAY_W-1:0] set_rr,
  output logic [WAYS-1:0]  way_oh,
  output logic             use_rr
);

  logic free_found;

  always_comb begin
    free_found = 1'b0;
    way_oh     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!set_vld[w] && !free_found) begin
        way_oh[w]  = 1'b1;
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      way_oh[set_rr] = 1'b1;
    end
    use_rr = !free_found;
  end

  // R7
  victim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(way_oh) == 1);

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vld != '1) |-> ((way_oh & set_vld) == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 22,
  parameter int OFF_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = safe_clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = safe_clog2(WAYS),
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic             req_write,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_vpn,
  input  logic             fill_valid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ro,
  input  logic             flush
);

  xlat_state_e state_q;

  logic [VPN_W-1:0] pend_vpn_q;
  logic [OFF_W-1:0] pend_off_q;
  logic             pend_wr_q;

  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][PPN_W-1:0] rd_ppn;
  logic [WAYS-1:0]            rd_ro;
  logic [WAYS-1:0]            rd_vld;
  logic [WAYS-1:0]            wr_vld;
  logic [WAY_W-1:0]           wr_rr;
  logic [WAYS-1:0]            vict_oh;
  logic                       vict_rr;

  logic             any_hit;
  logic [PPN_W-1:0] hit_ppn;
  logic             hit_ro;
  logic             accept;
  logic             look_hit;
  logic             fill_take;
  logic             install;

  assign req_ready = (state_q == XS_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_hit  = any_hit && !flush;
  assign fill_take = (state_q == XS_WAIT) && fill_valid;
  assign install   = fill_take && !flush;
  assign miss_vpn  = pend_vpn_q;

  xlat_store #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .rd_idx   (req_vpn[IDX_W-1:0]),
    .rd_tag   (rd_tag),
    .rd_ppn   (rd_ppn),
    .rd_ro    (rd_ro),
    .rd_vld   (rd_vld),
    .wr_en    (install),
    .wr_idx   (pend_vpn_q[IDX_W-1:0]),
    .wr_way   (vict_oh),
    .wr_rr_adv(vict_rr),
    .wr_tag   (pend_vpn_q[VPN_W-1:IDX_W]),
    .wr_ppn   (fill_ppn),
    .wr_ro    (fill_ro),
    .wr_vld   (wr_vld),
    .wr_rr    (wr_rr)
  );

  xlat_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_match (
    .clk    (clk),
    .rst    (rst),
    .tag    (req_vpn[VPN_W-1:IDX_W]),
    .rd_tag (rd_tag),
    .rd_ppn (rd_ppn),
    .rd_ro  (rd_ro),
    .rd_vld (rd_vld),
    .hit    (any_hit),
    .hit_ppn(hit_ppn),
    .hit_ro (hit_ro)
  );

  xlat_victim #(
    .WAYS(WAYS)
  ) u_victim (
    .clk    (clk),
    .rst    (rst),
    .set_vld(wr_vld),
    .set_rr (wr_rr),
    .way_oh (vict_oh),
    .use_rr (vict_rr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= XS_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      miss_req   <= 1'b0;
      pend_vpn_q <= '0;
      pend_off_q <= '0;
      pend_wr_q  <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      case (state_q)
        XS_IDLE: begin
          if (accept) begin
            if (look_hit) begin
              resp_valid <= 1'b1;
              if (req_write && hit_ro) begin
                resp_fault <= 1'b1;
              end else begin
                resp_hit   <= 1'b1;
                resp_paddr <= {hit_ppn, req_off};
              end
            end else begin
              pend_vpn_q <= req_vpn;
              pend_off_q <= req_off;
              pend_wr_q  <= req_write;
              miss_req   <= 1'b1;
              state_q    <= XS_WAIT;
            end
          end
        end
        XS_WAIT: begin
          if (fill_take) begin
            miss_req   <= 1'b0;
            state_q    <= XS_IDLE;
            resp_valid <= 1'b1;
            if (pend_wr_q && fill_ro) begin
              resp_fault <= 1'b1;
            end else begin
              resp_hit   <= 1'b1;
              resp_paddr <= {fill_ppn, pend_off_q};
            end
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!resp_valid && !miss_req));

  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && look_hit) |=> (resp_valid && !miss_req));

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_req && !fill_valid) |=> (miss_req && $stable(miss_vpn) && !req_ready));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> (resp_paddr == '0));

  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && flush) |=> (miss_req && !resp_valid));

  // R11
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_hit != resp_fault));

  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> (!resp_hit && !resp_fault));

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

  localparam int VPN_W = 20;
  localparam int PPN_W = 22;
  localparam int OFF_W = 12;
  localparam int PA_W  = PPN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             req_write = 1'b0;
  logic             resp_valid, resp_hit, resp_fault;
  logic [PA_W-1:0]  resp_paddr;
  logic             miss_req;
  logic [VPN_W-1:0] miss_vpn;
  logic             fill_valid = 1'b0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             fill_ro = 1'b0;
  logic             flush = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_off(req_off), .req_write(req_write),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .miss_req(miss_req), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_ro(fill_ro),
    .flush(flush)
  );

  function automatic logic [VPN_W-1:0] mk(input int tag, input int set);
    return {tag[15:0], set[3:0]};
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // Present one lookup; returns at the negedge after the accepting edge
  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o,
                      input logic w, input logic fl);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_off = o; req_write = w; flush = fl;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; flush = 1'b0;
  endtask

  // Return a mapping for the outstanding miss
  task automatic fill(input logic [PPN_W-1:0] p, input logic ro, input logic fl);
    fill_valid = 1'b1; fill_ppn = p; fill_ro = ro; flush = fl;
    @(negedge clk);
    fill_valid = 1'b0; fill_ro = 1'b0; flush = 1'b0;
  endtask

  task automatic exp_hit(input string rq, input logic [PPN_W-1:0] p,
                         input logic [OFF_W-1:0] o);
    chk(rq, "resp_valid", 64'(resp_valid), 64'd1);
    chk(rq, "resp_hit", 64'(resp_hit), 64'd1);
    chk("R11", "resp_fault", 64'(resp_fault), 64'd0);
    chk(rq, "resp_paddr", 64'(resp_paddr), 64'({p, o}));
    chk(rq, "miss_req", 64'(miss_req), 64'd0);
  endtask

  task automatic exp_fault(input string rq);
    chk(rq, "resp_valid", 64'(resp_valid), 64'd1);
    chk(rq, "resp_fault", 64'(resp_fault), 64'd1);
    chk("R11", "resp_hit", 64'(resp_hit), 64'd0);
    chk(rq, "resp_paddr", 64'(resp_paddr), 64'd0);
  endtask

  task automatic exp_miss(input string rq, input logic [VPN_W-1:0] v);
    chk(rq, "resp_valid", 64'(resp_valid), 64'd0);
    chk(rq, "miss_req", 64'(miss_req), 64'd1);
    chk(rq, "miss_vpn", 64'(miss_vpn), 64'(v));
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
    chk("R1", "miss_req", 64'(miss_req), 64'd0);
  endtask

  task automatic t_cold_miss();
    logic [VPN_W-1:0] v = mk(16'h0012, 3);
    look(v, 12'h345, 1'b0, 1'b0);
    exp_miss("R4", v);
    chk("R4", "req_ready", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R4", "miss_req held", 64'(miss_req), 64'd1);
    chk("R4", "miss_vpn held", 64'(miss_vpn), 64'(v));
    fill(22'h1ABCD, 1'b0, 1'b0);
    exp_hit("R5", 22'h1ABCD, 12'h345);
    look(v, 12'h0FF, 1'b1, 1'b0);
    exp_hit("R3", 22'h1ABCD, 12'h0FF);
  endtask

  task automatic t_sets();
    logic [VPN_W-1:0] a = mk(16'h0012, 5);
    logic [VPN_W-1:0] b = mk(16'h0013, 3);
    look(a, 12'h001, 1'b0, 1'b0);
    exp_miss("R2", a);
    fill(22'h00777, 1'b0, 1'b0);
    exp_hit("R5", 22'h00777, 12'h001);
    look(b, 12'h002, 1'b0, 1'b0);
    exp_miss("R2", b);
    fill(22'h00888, 1'b0, 1'b0);
    look(mk(16'h0012, 3), 12'h003, 1'b0, 1'b0);
    exp_hit("R2", 22'h1ABCD, 12'h003);
  endtask

  task automatic t_protect();
    logic [VPN_W-1:0] a = mk(16'h00AA, 7);
    logic [VPN_W-1:0] b = mk(16'h00AB, 7);
    look(a, 12'h010, 1'b0, 1'b0);
    fill(22'h02222, 1'b1, 1'b0);
    exp_hit("R6", 22'h02222, 12'h010);
    look(a, 12'h020, 1'b1, 1'b0);
    exp_fault("R6");
    chk("R6", "miss_req", 64'(miss_req), 64'd0);
    look(a, 12'h030, 1'b0, 1'b0);
    exp_hit("R6", 22'h02222, 12'h030);
    look(b, 12'h040, 1'b1, 1'b0);
    exp_miss("R4", b);
    fill(22'h03333, 1'b1, 1'b0);
    exp_fault("R6");
  endtask

  task automatic t_replace();
    for (int i = 0; i < 4; i++) begin
      look(mk(16'h0100 + i, 9), 12'h000, 1'b0, 1'b0);
      exp_miss("R7", mk(16'h0100 + i, 9));
      fill(22'(22'h500 + i), 1'b0, 1'b0);
    end
    for (int i = 0; i < 4; i++) begin
      look(mk(16'h0100 + i, 9), 12'h00C, 1'b0, 1'b0);
      exp_hit("R7", 22'(22'h500 + i), 12'h00C);
    end
    // all valid, pointer at 0: way0 (tag 0x100) goes
    look(mk(16'h0104, 9), 12'h000, 1'b0, 1'b0);
    fill(22'h504, 1'b0, 1'b0);
    for (int i = 1; i < 5; i++) begin
      look(mk(16'h0100 + i, 9), 12'h001, 1'b0, 1'b0);
      exp_hit("R7", 22'(22'h500 + i), 12'h001);
    end
    look(mk(16'h0100, 9), 12'h000, 1'b0, 1'b0);
    exp_miss("R7", mk(16'h0100, 9));
    fill(22'h600, 1'b0, 1'b0);              // evicts way1 (0x101)
    look(mk(16'h0101, 9), 12'h000, 1'b0, 1'b0);
    exp_miss("R7", mk(16'h0101, 9));
    fill(22'h601, 1'b0, 1'b0);              // evicts way2 (0x102)
    look(mk(16'h0103, 9), 12'h002, 1'b0, 1'b0);
    exp_hit("R7", 22'h503, 12'h002);
    look(mk(16'h0102, 9), 12'h000, 1'b0, 1'b0);
    exp_miss("R7", mk(16'h0102, 9));
    fill(22'h602, 1'b0, 1'b0);              // evicts way3 (0x103)
    look(mk(16'h0100, 9), 12'h004, 1'b0, 1'b0);
    exp_hit("R7", 22'h600, 12'h004);
    look(mk(16'h0104, 9), 12'h005, 1'b0, 1'b0);
    exp_hit("R7", 22'h504, 12'h005);
  endtask

  task automatic t_flush();
    logic [VPN_W-1:0] v = mk(16'h0012, 3);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    look(v, 12'h111, 1'b0, 1'b0);
    exp_miss("R8", v);
    fill(22'h1ABCD, 1'b0, 1'b0);
    look(mk(16'h0100, 9), 12'h000, 1'b0, 1'b0);
    exp_miss("R8", mk(16'h0100, 9));
    fill(22'h600, 1'b0, 1'b0);
  endtask

  task automatic t_flush_lookup();
    logic [VPN_W-1:0] v = mk(16'h0012, 3);
    look(v, 12'h222, 1'b0, 1'b0);
    exp_hit("R9", 22'h1ABCD, 12'h222);
    look(v, 12'h223, 1'b0, 1'b1);
    exp_miss("R9", v);
    fill(22'h1ABCD, 1'b0, 1'b0);
    exp_hit("R9", 22'h1ABCD, 12'h223);
    look(v, 12'h224, 1'b0, 1'b0);
    exp_hit("R9", 22'h1ABCD, 12'h224);
  endtask

  task automatic t_flush_fill();
    logic [VPN_W-1:0] v = mk(16'h0ABC, 12);
    look(v, 12'h333, 1'b0, 1'b0);
    exp_miss("R10", v);
    fill(22'h0F0F0, 1'b0, 1'b1);
    exp_hit("R10", 22'h0F0F0, 12'h333);
    look(v, 12'h334, 1'b0, 1'b0);
    exp_miss("R10", v);
    fill(22'h0F0F1, 1'b0, 1'b0);
    exp_hit("R10", 22'h0F0F1, 12'h334);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_sets();
    t_protect();
    t_replace();
    t_flush();
    t_flush_lookup();
    t_flush_fill();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule